// File: doc/BRIEF.md
# DRAM Cycle Timing Sequencer

This block drives the row strobe, column strobe, transfer-ready and refresh strobes for one DRAM bank. It runs on a clock at twice the T-state rate, so every timing value is counted in half-T clocks. Placing a column strobe on a half-T boundary is therefore an ordinary count. An 8-bit timing word and a refresh-enable input set the timing. The timing word is latched whenever the sequencer starts a cycle, either an access or a refresh. A value changed later has no effect until the next cycle starts.

The CPU side raises `req_i` together with direction, burst and page-hit qualifiers, and holds them until `req_ack_o` is high. The acknowledge pulses in the clock where the request is taken. After an access the row stays open, so a later request flagged as a page hit skips the row phase. A miss closes the row and waits out the precharge before it opens a new row. Refresh requests are queued and are served only while the sequencer is idle. A refresh takes priority over an access that is waiting. Bank decode, interleaving, parity and address multiplexing are handled elsewhere.

Top module: `dram_timing_seq`

## Requirements
- R1: Timing bits [1:0] select the read profile in clocks (1 T = 2 clocks). The first transfer of a row miss and each page-hit beat are 00: 6 and 4, 01: 8 and 6, 10 or 11: 10 and 8 clocks. Each transfer ends with a ready pulse.
- R2: On a row miss the column strobe first asserts this many clocks after the row strobe rises. With bits [1:0]=00 the count is 3 when bit 2=0 and 5 when bit 2=1. Otherwise it is 4 when bit 2=0 and 6 when bit 2=1. The count is capped at the transfer length minus one.
- R3: A single write on a row miss lasts 6 clocks when bit 4=0 and 8 clocks when bit 4=1. Write page-hit beats last 4 clocks when bit 6=0 and 6 clocks when bit 6=1.
- R4: When the row is open, a request flagged as a page hit starts its first transfer in the clock after acceptance, with beat length. The row strobe does not drop.
- R5: The row strobe stays low for at least 4 clocks (bit 5=0) or 6 clocks (bit 5=1) before it rises again. A miss with the row open takes exactly that long: the row strobe rises at the end of the last precharge clock.
- R6: A refresh holds the refresh strobe and the row strobe high, with the column strobe low, for 6 clocks (bit 7=0) or 8 clocks (bit 7=1). It is preceded by row close and precharge.
- R7: While `ref_en_i` is low, refresh requests are dropped. No refresh strobe appears and an open row stays open.
- R8: A refresh requested during an access is held pending. It starts after the access has finished and precharge has been met.
- R9: Every transfer ends with a ready pulse exactly one clock wide, and the column strobe is high in that clock. A burst has BURST_LEN transfers and a single access has one.
- R10: The timing word is sampled when a cycle starts. Changing it during the cycle leaves that cycle's timing unchanged.
- R11: After reset all strobes and the acknowledge are low, the row is closed, and the timing word is 00h.
- R12: The column strobe is never high while the row strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock at twice the T-state rate |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tim_cfg_i | input | 8 | Timing word; bit 3 is reserved and ignored |
| ref_en_i | input | 1 | Enables refresh cycles |
| ref_req_i | input | 1 | Refresh request pulse |
| req_i | input | 1 | Access request, held until acknowledged |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_burst_i | input | 1 | 1 = BURST_LEN transfers, 0 = one transfer |
| req_hit_i | input | 1 | Request targets the currently open row |
| req_ack_o | output | 1 | Request accepted in this clock |
| ras_o | output | 1 | Row strobe, active high |
| cas_o | output | 1 | Column strobe, active high |
| rdy_o | output | 1 | Transfer complete, one clock per transfer |
| ref_o | output | 1 | Refresh row pulse in progress |

## Verification
The bench builds the block with the default BURST_LEN of 4, so that every burst shows one lead-off transfer followed by three page-hit beats. It sweeps all 128 timing words whose reserved bit is clear. For each word it runs a read miss, a read hit, a write miss, a write burst hit and, for alternate words, a refresh. This covers every combination of profile, row-to-column delay, write timing, precharge and refresh width, with the row both open and closed. Directed runs then cover a refresh queued behind a burst and a timing word that changes during a burst.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;
  localparam int CNT_W = 4;

  typedef enum logic [1:0] {ST_IDLE, ST_PRE, ST_XFER, ST_REF} seq_state_e;

  // all lengths in half-T clocks
  typedef struct packed {
    logic [CNT_W-1:0] rd_first;
    logic [CNT_W-1:0] rd_beat;
    logic [CNT_W-1:0] wr_first;
    logic [CNT_W-1:0] wr_beat;
    logic [CNT_W-1:0] ras_cas;
    logic [CNT_W-1:0] pre_need;
    logic [CNT_W-1:0] ref_width;
  } tim_t;
endpackage

// File: rtl/dram_tcfg_decode.sv
module dram_tcfg_decode
  import dram_seq_pkg::*;
(
  input  logic [7:0] cfg_i,
  output tim_t       tim_o
);
  logic [CNT_W-1:0] lead;
  logic             half_mode;
  logic             unused_rsvd_bit;

  assign unused_rsvd_bit = cfg_i[3];
  assign half_mode = (cfg_i[1:0] == 2'b00);

  always_comb begin
    unique case (cfg_i[1:0])
      2'b00:   lead = CNT_W'(3);
      2'b01:   lead = CNT_W'(4);
      default: lead = CNT_W'(5);
    endcase
    tim_o.rd_first  = lead << 1;
    tim_o.rd_beat   = (lead - CNT_W'(1)) << 1;
    if (half_mode) tim_o.ras_cas = cfg_i[2] ? CNT_W'(5) : CNT_W'(3);
    else           tim_o.ras_cas = cfg_i[2] ? CNT_W'(6) : CNT_W'(4);
    tim_o.wr_first  = cfg_i[4] ? CNT_W'(8) : CNT_W'(6);
    tim_o.pre_need  = cfg_i[5] ? CNT_W'(6) : CNT_W'(4);
    tim_o.wr_beat   = cfg_i[6] ? CNT_W'(6) : CNT_W'(4);
    tim_o.ref_width = cfg_i[7] ? CNT_W'(8) : CNT_W'(6);
  end
endmodule

// File: rtl/dram_prech_timer.sv
module dram_prech_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ras_i,
  input  logic [CNT_W-1:0] need_i,
  output logic             ok_o
);
  logic [CNT_W-1:0] cnt_q;

  // counts low clocks minus one; saturates
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '1;
    else if (ras_i)            cnt_q <= '0;
    else if (cnt_q != '1)      cnt_q <= cnt_q + CNT_W'(1);
  end

  assign ok_o = (cnt_q >= need_i - CNT_W'(1));
endmodule

// File: rtl/dram_timing_seq.sv
module dram_timing_seq
  import dram_seq_pkg::*;
#(
  parameter int BURST_LEN = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [7:0] tim_cfg_i,
  input  logic       ref_en_i,
  input  logic       ref_req_i,
  input  logic       req_i,
  input  logic       req_we_i,
  input  logic       req_burst_i,
  input  logic       req_hit_i,
  output logic       req_ack_o,
  output logic       ras_o,
  output logic       cas_o,
  output logic       rdy_o,
  output logic       ref_o
);
  localparam int BEAT_W = (BURST_LEN > 2) ? $clog2(BURST_LEN) : 1;

  seq_state_e       state_q;
  logic [7:0]       cfg_q;
  logic             we_q, burst_q, hit_q, first_q, ref_op_q;
  logic             ras_q, page_open_q, ref_pend_q;
  logic [BEAT_W-1:0] beat_q;
  logic [CNT_W-1:0] tcnt_q;

  tim_t             tim;
  logic [CNT_W-1:0] pre_need;
  logic             prech_ok;
  logic [CNT_W-1:0] first_len, cur_len, cas_start;
  logic             ref_go, acc, hit_go, xfer_end, last_beat, ref_end;

  dram_tcfg_decode i_dec (
    .cfg_i (cfg_q),
    .tim_o (tim)
  );

  assign pre_need = tim.pre_need;

  dram_prech_timer #(.CNT_W(CNT_W)) i_prech (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ras_i  (ras_q),
    .need_i (pre_need),
    .ok_o   (prech_ok)
  );

  assign ref_go = (state_q == ST_IDLE) && ref_pend_q;
  assign acc    = (state_q == ST_IDLE) && !ref_pend_q && req_i;
  assign hit_go = acc && page_open_q && req_hit_i;

  always_comb begin
    if (we_q) first_len = hit_q ? tim.wr_beat : tim.wr_first;
    else      first_len = hit_q ? tim.rd_beat : tim.rd_first;
    cur_len = first_q ? first_len : (we_q ? tim.wr_beat : tim.rd_beat);
    // miss lead-off: column strobe after row-to-column delay, at least one clock wide
    if (first_q && !hit_q)
      cas_start = (tim.ras_cas < cur_len) ? tim.ras_cas : cur_len - CNT_W'(1);
    else
      cas_start = cur_len - CNT_W'(2);
  end

  assign xfer_end  = (state_q == ST_XFER) && (tcnt_q == cur_len - CNT_W'(1));
  assign last_beat = !burst_q || (beat_q == BEAT_W'(BURST_LEN - 1));
  assign ref_end   = (state_q == ST_REF) && (tcnt_q == tim.ref_width - CNT_W'(1));

  assign req_ack_o = acc;
  assign ras_o     = ras_q;
  assign cas_o     = (state_q == ST_XFER) && (tcnt_q >= cas_start);
  assign rdy_o     = xfer_end;
  assign ref_o     = (state_q == ST_REF);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            ref_pend_q <= 1'b0;
    else if (!ref_en_i)     ref_pend_q <= 1'b0;
    else if (ref_req_i)     ref_pend_q <= 1'b1;
    else if (ref_go)        ref_pend_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      cfg_q       <= '0;
      we_q        <= 1'b0;
      burst_q     <= 1'b0;
      hit_q       <= 1'b0;
      first_q     <= 1'b0;
      ref_op_q    <= 1'b0;
      ras_q       <= 1'b0;
      page_open_q <= 1'b0;
      beat_q      <= '0;
      tcnt_q      <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (ref_go) begin
            cfg_q       <= tim_cfg_i;
            ras_q       <= 1'b0;
            page_open_q <= 1'b0;
            ref_op_q    <= 1'b1;
            state_q     <= ST_PRE;
          end else if (acc) begin
            cfg_q   <= tim_cfg_i;
            we_q    <= req_we_i;
            burst_q <= req_burst_i;
            beat_q  <= '0;
            first_q <= 1'b1;
            tcnt_q  <= '0;
            if (hit_go) begin
              hit_q   <= 1'b1;
              state_q <= ST_XFER;
            end else begin
              hit_q       <= 1'b0;
              ras_q       <= 1'b0;
              page_open_q <= 1'b0;
              ref_op_q    <= 1'b0;
              state_q     <= ST_PRE;
            end
          end
        end
        ST_PRE: begin
          if (prech_ok) begin
            ras_q   <= 1'b1;
            tcnt_q  <= '0;
            state_q <= ref_op_q ? ST_REF : ST_XFER;
          end
        end
        ST_XFER: begin
          if (xfer_end) begin
            tcnt_q <= '0;
            if (last_beat) begin
              page_open_q <= 1'b1;
              state_q     <= ST_IDLE;
            end else begin
              beat_q  <= beat_q + BEAT_W'(1);
              first_q <= 1'b0;
            end
          end else begin
            tcnt_q <= tcnt_q + CNT_W'(1);
          end
        end
        ST_REF: begin
          if (ref_end) begin
            ras_q   <= 1'b0;
            tcnt_q  <= '0;
            state_q <= ST_IDLE;
          end else begin
            tcnt_q <= tcnt_q + CNT_W'(1);
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dram_timing_seq_chk.sv
module dram_timing_seq_chk
  import dram_seq_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ras_i,
  input logic             cas_i,
  input logic             rdy_i,
  input logic             ref_i,
  input logic [CNT_W-1:0] pre_need_i
);
  logic [CNT_W-1:0] low_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             low_cnt <= '1;
    else if (ras_i)          low_cnt <= '0;
    else if (low_cnt != '1)  low_cnt <= low_cnt + CNT_W'(1);
  end

  // R5
  prech_min_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ras_i) |-> low_cnt >= pre_need_i);

  // R9
  rdy_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdy_i |=> !rdy_i);

  // R9
  rdy_cas_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdy_i |-> cas_i);

  // R12
  cas_ras_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cas_i |-> ras_i);

  // R6
  ref_nocas_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_i |-> (ras_i && !cas_i));

  // R6
  ref_no_rdy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_i |-> !rdy_i);
endmodule

bind dram_timing_seq dram_timing_seq_chk i_dram_timing_seq_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .ras_i      (ras_o),
  .cas_i      (cas_o),
  .rdy_i      (rdy_o),
  .ref_i      (ref_o),
  .pre_need_i (pre_need)
);

// File: tb/test_dram_timing_seq.sv
module test_dram_timing_seq;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [7:0] tim_cfg = 8'h00;
  logic ref_en = 1'b1, ref_req = 1'b0;
  logic req = 1'b0, req_we = 1'b0, req_burst = 1'b0, req_hit = 1'b0;
  logic req_ack, ras, cas, rdy, refo;

  always #10 clk = ~clk;

  dram_timing_seq i_dram_timing_seq (
    .clk_i(clk), .rst_ni(rst_ni), .tim_cfg_i(tim_cfg), .ref_en_i(ref_en),
    .ref_req_i(ref_req), .req_i(req), .req_we_i(req_we), .req_burst_i(req_burst),
    .req_hit_i(req_hit), .req_ack_o(req_ack), .ras_o(ras), .cas_o(cas),
    .rdy_o(rdy), .ref_o(refo)
  );

  int checks = 0, fails = 0, cas_viol = 0;
  int rdy_cyc[8];
  int n_rdy, cas_first, ras_rise, ref_first, ref_len, ras_falls;
  logic prev_ras;

  task automatic check(input string r, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  // R12 monitor
  always @(negedge clk) if (rst_ni && cas && !ras) cas_viol++;

  // caller stands at the negedge of cycle 1
  task automatic capture(input int win, input int ref_at, input int chg_at, input logic [7:0] chg_cfg);
    n_rdy = 0; cas_first = -1; ras_rise = -1; ref_first = -1; ref_len = 0; ras_falls = 0;
    for (int c = 1; c <= win; c++) begin
      if (c > 1) @(negedge clk);
      ref_req = (c == ref_at);
      if (c == chg_at) tim_cfg = chg_cfg;
      if (rdy && n_rdy < 8) begin rdy_cyc[n_rdy] = c; n_rdy++; end
      if (cas && cas_first < 0) cas_first = c;
      if (ras && !prev_ras && ras_rise < 0) ras_rise = c;
      if (!ras && prev_ras) ras_falls++;
      if (refo) begin if (ref_first < 0) ref_first = c; ref_len++; end
      prev_ras = ras;
    end
    ref_req = 1'b0;
  endtask

  task automatic run_acc(input logic we, input logic burst, input logic hit, input int win,
                         input int ref_at, input int chg_at, input logic [7:0] chg_cfg);
    @(negedge clk);
    req = 1'b1; req_we = we; req_burst = burst; req_hit = hit;
    #1;
    while (!req_ack) begin @(negedge clk); #1; end
    prev_ras = ras;
    @(negedge clk);
    req = 1'b0;
    capture(win, ref_at, chg_at, chg_cfg);
  endtask

  task automatic run_ref(input int win);
    @(negedge clk);
    ref_req = 1'b1;
    prev_ras = ras;
    @(negedge clk);
    ref_req = 1'b0;
    capture(win, 0, 0, 8'h00);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R9: actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic page_open;
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11 ras", int'(ras), 0);
    check("R11 cas", int'(cas), 0);
    check("R11 rdy", int'(rdy), 0);
    check("R11 ref", int'(refo), 0);
    check("R11 ack", int'(req_ack), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    check("R11 ras after release", int'(ras), 0);
    page_open = 1'b0;

    for (int i = 0; i < 128; i++) begin
      logic [7:0] cfg;
      int lead, rdf, rdb, rc, wrf, wrb, need, wid, d, cs;
      cfg = {i[6:3], 1'b0, i[2:0]};
      lead = (cfg[1:0] == 2'b00) ? 3 : (cfg[1:0] == 2'b01) ? 4 : 5;
      rdf = 2 * lead; rdb = 2 * (lead - 1);
      rc = (cfg[1:0] == 2'b00) ? (cfg[2] ? 5 : 3) : (cfg[2] ? 6 : 4);
      wrf = cfg[4] ? 8 : 6; wrb = cfg[6] ? 6 : 4;
      need = cfg[5] ? 6 : 4; wid = cfg[7] ? 8 : 6;
      @(negedge clk);
      tim_cfg = cfg;

      // read burst, row miss
      d = page_open ? need : 1;
      run_acc(1'b0, 1'b1, 1'b0, d + rdf + 3 * rdb + 1, 0, 0, 8'h00);
      check("R9 read burst count", n_rdy, 4);
      for (int k = 0; k < 4; k++) check("R1 read ready", rdy_cyc[k], d + rdf + k * rdb);
      cs = (rc < rdf) ? rc : rdf - 1;
      check("R2 read ras-cas", cas_first, d + 1 + cs);
      check("R5 read ras rise", ras_rise, d + 1);

      // read single, page hit
      run_acc(1'b0, 1'b0, 1'b1, rdb + 1, 0, 0, 8'h00);
      check("R4 read hit ready", rdy_cyc[0], rdb);
      check("R9 read hit count", n_rdy, 1);
      check("R4 read hit ras kept", ras_falls, 0);

      // write single, row miss with open row
      run_acc(1'b1, 1'b0, 1'b0, need + wrf + 1, 0, 0, 8'h00);
      check("R3 write miss ready", rdy_cyc[0], need + wrf);
      cs = (rc < wrf) ? rc : wrf - 1;
      check("R2 write ras-cas", cas_first, need + 1 + cs);
      check("R5 precharge", ras_rise, need + 1);

      // write burst, page hit
      run_acc(1'b1, 1'b1, 1'b1, 4 * wrb + 1, 0, 0, 8'h00);
      check("R9 write burst count", n_rdy, 4);
      for (int k = 0; k < 4; k++) check("R3 write beat", rdy_cyc[k], (k + 1) * wrb);
      page_open = 1'b1;

      if ((i % 16) == 6) begin
        ref_en = 1'b0;
        run_ref(20);
        check("R7 no refresh", ref_len, 0);
        check("R7 row kept open", ras_falls, 0);
        ref_en = 1'b1;
      end

      if (i[0]) begin
        run_ref(need + wid + 3);
        check("R6 refresh start", ref_first, need + 2);
        check("R6 refresh width", ref_len, wid);
        repeat (12) @(negedge clk);
        page_open = 1'b0;
      end
    end

    // R8: refresh queued during a burst (cfg 00h, row closed after last refresh)
    @(negedge clk);
    tim_cfg = 8'h00;
    run_acc(1'b0, 1'b1, 1'b0, 40, 3, 0, 8'h00);
    check("R8 burst unaffected", rdy_cyc[3], 19);
    check("R8 pending refresh start", ref_first, 19 + 2 + 4);
    check("R8 pending refresh width", ref_len, 6);
    repeat (12) @(negedge clk);

    // R10: timing word changed mid-burst
    @(negedge clk);
    tim_cfg = 8'h22;
    run_acc(1'b0, 1'b1, 1'b0, 40, 0, 2, 8'h00);
    for (int k = 0; k < 4; k++) check("R10 latched timing", rdy_cyc[k], 1 + 10 + k * 8);
    // next hit uses the new word 00h
    run_acc(1'b0, 1'b0, 1'b1, 6, 0, 0, 8'h00);
    check("R10 new word on next cycle", rdy_cyc[0], 4);

    check("R12 cas without ras", cas_viol, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule